// File: doc/BRIEF.md
# SRAM Page-Mode Read Burst Engine

This block reads a short run of consecutive words from an asynchronous static RAM that has a page read mode. The RAM is organised in aligned pages of eight words. The first read after the chip is selected pays the full random-access time. Each later read in the same page changes only the three lowest address bits, and it completes in the shorter page access time. The engine takes one request made of a start address and a word count. It holds chip select and output enable low for the whole burst. It steps the low address bits and returns each word on a one-cycle output strobe, with a last flag on the final word.

A burst never leaves the page that its start address lies in. When the request asks for more words than remain before the page end, the engine stops at the page end. On the last word it reports that the burst was cut short, together with the number of words it actually delivered. After every burst it deselects the RAM and stays idle for one full read cycle time before it takes the next request.

All waits are counted in clock cycles set by parameters. The defaults suit a 10 ns clock: three cycles for the first word, two for each page word, and three for the gap between bursts.

Top module: `page_burst_reader`

## Requirements
- R1: After reset, req_ready is 1, mem_cs_n and mem_oe_n are 1, and out_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready then stays 0 until recovery ends. A req_count of 0 is treated as a request for one word.
- R3: The first word is captured only after its address has been driven, with mem_cs_n and mem_oe_n low, for FIRST_CYC cycles (3 by default).
- R4: Between words of one burst, address bits [ADDR_W-1:3] stay constant. Bits [2:0] step up by exactly one, and each new address is held PAGE_CYC cycles (2 by default) before its word is captured.
- R5: mem_cs_n and mem_oe_n are both low, without a gap, from the first address of a burst until its last word is captured. They always carry the same value.
- R6: A burst delivers min(max(req_count,1), 8 - req_addr[2:0]) words, in ascending address order. Each word is shown by a one-cycle out_valid pulse, with out_data equal to the RAM data at that address.
- R7: out_last is 1 on the final word of a burst and 0 on every other beat.
- R8: On the last beat, out_trunc is 1 exactly when the effective count exceeds 8 - req_addr[2:0], and out_words gives the number of words delivered. On other beats both are 0.
- R9: After the last capture, mem_cs_n and mem_oe_n go high and stay high for at least REC_CYC cycles (3 by default) before the next burst selects the RAM. req_ready is 1 only while the RAM is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_addr | input | ADDR_W | Start word address |
| req_count | input | PAGE_BITS+1 | Requested words (0 counts as 1) |
| req_ready | output | 1 | Engine idle and able to take a request |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_rdata | input | DATA_W | RAM read data |
| out_valid | output | 1 | One-cycle strobe for a delivered word |
| out_data | output | DATA_W | Delivered word |
| out_last | output | 1 | Final word of the burst |
| out_trunc | output | 1 | Burst was stopped at the page end (last beat only) |
| out_words | output | PAGE_BITS+1 | Words delivered (last beat only) |

## Verification
The RAM model in the bench returns a poison value whenever an address has not been held long enough. A new page needs three cycles and a page step needs two. As a result, an engine that samples early, or that treats the first word as a page word, delivers wrong data. Bursts start at offset 7, at other offsets near the page end, and at the top of the address space. These show whether an engine runs past the boundary, wraps into the next page, or gets the truncation flag or word count off by one. A zero count, an exact fit with no truncation, and back-to-back requests cover the effective-count rule and the gap the RAM needs between bursts.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RECOVER = 2'd2
    } burst_state_e;

    // Largest of three cycle counts, used to size the wait timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Words a burst may deliver: the effective count clipped to the page room.
    function automatic int words_in_burst(input int req, input int room);
        int eff;
        eff = (req == 0) ? 1 : req;
        return (eff > room) ? room : eff;
    endfunction

endpackage

// File: rtl/burst_plan.sv
module burst_plan
    import sram_burst_pkg::*;
#(
    parameter int PAGE_BITS = 3
) (
    input  logic [PAGE_BITS-1:0] start_lo,
    input  logic [PAGE_BITS:0]   want,
    output logic [PAGE_BITS:0]   n_words,
    output logic                 clipped
);
    localparam int PAGE  = 1 << PAGE_BITS;
    localparam int CNT_W = PAGE_BITS + 1;

    always_comb begin
        int room;
        int eff;
        room    = PAGE - int'(start_lo);
        eff     = (want == '0) ? 1 : int'(want);
        n_words = CNT_W'(words_in_burst(int'(want), room));
        clipped = (eff > room);
    end

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/page_burst_reader.sv
module page_burst_reader
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 3,
    parameter int FIRST_CYC = 3,
    parameter int PAGE_CYC  = 2,
    parameter int REC_CYC   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [PAGE_BITS:0]   req_count,
    output logic                 req_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_cs_n,
    output logic                 mem_oe_n,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_last,
    output logic                 out_trunc,
    output logic [PAGE_BITS:0]   out_words
);
    localparam int CNT_W = PAGE_BITS + 1;
    localparam int PAGE  = 1 << PAGE_BITS;
    localparam int TW    = $clog2(max3(FIRST_CYC, PAGE_CYC, REC_CYC) + 1);

    burst_state_e          state;
    logic [ADDR_W-1:0]     addr_q;
    logic [CNT_W-1:0]      left_q;
    logic [CNT_W-1:0]      done_q;
    logic                  trunc_q;
    logic [CNT_W-1:0]      plan_words;
    logic                  plan_trunc;
    logic                  tmr_load;
    logic [TW-1:0]         tmr_val;
    logic                  tmr_zero;
    logic                  take;
    logic                  final_word;

    burst_plan #(.PAGE_BITS(PAGE_BITS)) u_plan (
        .start_lo (req_addr[PAGE_BITS-1:0]),
        .want     (req_count),
        .n_words  (plan_words),
        .clipped  (plan_trunc)
    );

    wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    assign take       = (state == ST_IDLE) && req_valid;
    assign final_word = (left_q == CNT_W'(1));

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (take) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(FIRST_CYC - 1);
        end else if (state == ST_ACCESS && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = final_word ? TW'(REC_CYC - 1) : TW'(PAGE_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            left_q    <= '0;
            done_q    <= '0;
            trunc_q   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            out_trunc <= 1'b0;
            out_words <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_trunc <= 1'b0;
            out_words <= '0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        state   <= ST_ACCESS;
                        addr_q  <= req_addr;
                        left_q  <= plan_words;
                        done_q  <= '0;
                        trunc_q <= plan_trunc;
                    end
                end
                ST_ACCESS: begin
                    if (tmr_zero) begin
                        out_valid <= 1'b1;
                        out_data  <= mem_rdata;
                        done_q    <= done_q + CNT_W'(1);
                        left_q    <= left_q - CNT_W'(1);
                        if (final_word) begin
                            state     <= ST_RECOVER;
                            out_last  <= 1'b1;
                            out_trunc <= trunc_q;
                            out_words <= done_q + CNT_W'(1);
                        end else begin
                            addr_q[PAGE_BITS-1:0] <= addr_q[PAGE_BITS-1:0] + 1'b1;
                        end
                    end
                end
                ST_RECOVER: begin
                    if (tmr_zero) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_addr  = addr_q;
    assign mem_cs_n  = (state != ST_ACCESS);
    assign mem_oe_n  = (state != ST_ACCESS);

    // R4: the page part of the address is frozen while the RAM stays selected
    a_r4_page_frozen: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |->
            mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS]));

    // R4: inside a burst the low bits only ever step up by one
    a_r4_low_step: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n) && mem_addr != $past(mem_addr)) |->
            mem_addr[PAGE_BITS-1:0] == $past(mem_addr[PAGE_BITS-1:0]) + 1'b1);

    // R5: output enable follows chip select
    a_r5_oe_tracks_cs: assert property (@(posedge clk) disable iff (rst)
        mem_oe_n == mem_cs_n);

    // R6: the planned word count is non-zero and stays inside the page
    a_r6_plan_fits: assert property (@(posedge clk) disable iff (rst)
        take |-> (plan_words != '0) &&
                 (int'(plan_words) + int'(req_addr[PAGE_BITS-1:0]) <= PAGE));

    // R7: last only on a delivered beat
    a_r7_last_is_beat: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R8: truncation and the word count appear only with last
    a_r8_trunc_on_last: assert property (@(posedge clk) disable iff (rst)
        (out_trunc || out_words != '0) |-> out_last);

    // R9: ready only while the RAM is deselected
    a_r9_ready_deselected: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n);

    // R9: the RAM is released right after the last capture
    a_r9_release_after_last: assert property (@(posedge clk) disable iff (rst)
        out_last |-> mem_cs_n);

endmodule

// File: tb/sim_page_burst_reader.sv
module sim_page_burst_reader;

    localparam int AW = 20;
    localparam int DW = 16;

    typedef struct {
        logic [DW-1:0] d;
        logic          last;
        logic          tr;
        logic [3:0]    w;
        int            req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_count = '0;
    logic          req_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n;
    logic [DW-1:0] mem_rdata;
    logic          out_valid, out_last, out_trunc;
    logic [DW-1:0] out_data;
    logic [3:0]    out_words;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    page_burst_reader u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .req_ready(req_ready), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_trunc(out_trunc), .out_words(out_words)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A5};
    endfunction

    // RAM model: data is good only once the address has been held long enough
    logic [AW-1:0] prev_a = '0;
    int            stable = 0;
    int            need   = 3;
    bit            open_pg = 1'b0;

    always @(negedge clk) begin
        if (mem_cs_n) begin
            open_pg = 1'b0;
            stable  = 0;
        end else if (!open_pg || mem_addr != prev_a) begin
            need    = (open_pg && mem_addr[AW-1:3] == prev_a[AW-1:3]) ? 2 : 3;
            open_pg = 1'b1;
            stable  = 1;
            prev_a  = mem_addr;
        end else begin
            stable  = stable + 1;
        end
    end

    assign mem_rdata = (!mem_cs_n && !mem_oe_n && stable >= need) ? pat(mem_addr) : 16'hBAD0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: pushes the expected beats, then issues the request
    task automatic burst(input logic [AW-1:0] a, input int c);
        int eff, room, n;
        eff  = (c == 0) ? 1 : c;
        room = 8 - int'(a[2:0]);
        n    = (eff > room) ? room : eff;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.d    = pat({a[AW-1:3], 3'(int'(a[2:0]) + i)});
            e.last = (i == n - 1);
            e.tr   = (i == n - 1) && (eff > room);
            e.w    = (i == n - 1) ? 4'(n) : 4'd0;
            e.req  = (eff > room) ? 8 : 6;
            q.push_back(e);
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_count = 4'(c);
        @(negedge clk);
        req_valid = 1'b0;
        // R2: the request has been taken
        check(!req_ready, "R2", {31'd0, req_ready}, 32'd0);
    endtask

    // Monitor: compares delivered beats and checks the deselect gap
    int  gap = 100;
    bit  was_hi = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R6", {16'd0, out_data}, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_data == e.d, "R6", {16'd0, out_data}, {16'd0, e.d});
                    check(out_last == e.last, "R7", {31'd0, out_last}, {31'd0, e.last});
                    check(out_trunc == e.tr, "R8", {31'd0, out_trunc}, {31'd0, e.tr});
                    check(out_words == e.w, "R8", {28'd0, out_words}, {28'd0, e.w});
                end
            end
            if (!mem_cs_n && was_hi) begin
                // R9: gap before a new selection
                check(gap >= 3, "R9", gap, 3);
            end
            if (!mem_cs_n) begin
                // R5: enable held with chip select
                check(!mem_oe_n, "R5", {31'd0, mem_oe_n}, 32'd0);
                gap = 0;
            end else begin
                gap++;
            end
            was_hi = mem_cs_n;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", {31'd0, req_ready}, 32'd1);
        check(mem_cs_n && mem_oe_n, "R1", {30'd0, mem_cs_n, mem_oe_n}, 32'd3);
        check(!out_valid, "R1", {31'd0, out_valid}, 32'd0);

        burst(20'h12340, 8);   // R3 R4 R6: full page
        burst(20'h00005, 2);   // R6: short burst mid page
        burst(20'hABCD3, 8);   // R8: clipped to five
        burst(20'h00007, 1);   // R6: single word at page end
        burst(20'h00007, 3);   // R8: clipped to one
        burst(20'h0A0A1, 0);   // R2: zero count acts as one
        burst(20'hFFFF8, 8);   // R4: top page, no wrap
        burst(20'h55552, 6);   // R8: exact fit, not clipped
        burst(20'h33336, 4);   // R8: clipped to two
        burst(20'h77770, 3);   // R6: back-to-back request

        while (q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        // R9: idle and deselected after the last burst
        check(req_ready && mem_cs_n, "R9", {30'd0, req_ready, mem_cs_n}, 32'd3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0 pending beats", q.size());
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule